// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block produces the address for each beat of a four-beat memory burst. When either of two address strobes is asserted on a clock edge, the block captures the presented address. The upper bits are held unchanged for the whole burst. The two lowest bits become the starting beat offset. On every later edge where the active-low advance input is low, the burst moves on by one beat. After the fourth beat it wraps back to the starting offset, and the upper bits never change.

A static strap selects the beat order. Low selects a linear order, in which the offset counts up by one modulo four. High selects an interleaved order, in which the offset is the starting offset XORed with the beat number. The block drives the current two-bit offset and the complete burst address, which is the held upper bits joined with the offset. The external reset is active low and asynchronous. Its release is synchronised inside the block, so the block stays in reset for two further clock edges after the reset input rises.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is applied, and until the first load after reset, `beat_ofs_o` is 0 and `burst_addr_o` is 0.
- R2: A clock edge with `strb_a_i` or `strb_b_i` high (or both high) loads a burst. After that edge `beat_ofs_o` equals `start_addr_i[1:0]` and `burst_addr_o` equals `start_addr_i`.
- R3: During a burst, each edge with `adv_n_i` low moves on by one beat. An edge with `adv_n_i` high leaves both outputs unchanged.
- R4: With `order_sel_i` = 0 (linear), the offset at beat k is (start + k) mod 4. A start of 2 gives 2, 3, 0, 1.
- R5: With `order_sel_i` = 1 (interleaved), the offset at beat k is start XOR k. A start of 1 gives 1, 0, 3, 2.
- R6: The fourth advance returns the offset to the starting offset, and it never carries into `burst_addr_o[ADDR_W-1:2]`.
- R7: When a strobe and `adv_n_i` low arrive on the same edge, the load wins. The offset becomes the new start, at beat 0.
- R8: An advance that arrives before any load since reset has no effect. Both outputs stay at 0.
- R9: `burst_addr_o[ADDR_W-1:2]` holds the upper bits captured at the last load until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strb_a_i | input | 1 | First address strobe, active high, loads a burst |
| strb_b_i | input | 1 | Second address strobe, active high, loads a burst |
| start_addr_i | input | ADDR_W | External address, sampled when a strobe is high |
| adv_n_i | input | 1 | Advance, active low, moves on by one beat |
| order_sel_i | input | 1 | Static strap: 0 = linear order, 1 = interleaved order |
| beat_ofs_o | output | 2 | Current beat offset |
| burst_addr_o | output | ADDR_W | Held upper address bits joined with the current offset |

## Verification
The bench targets start offsets where the two orders differ: a start of 1 or 3 separates adding from XOR. An order swapped or built wrongly would therefore give 2 instead of 0 on the second beat. It runs each burst past the fourth advance, using upper address bits set to all ones. A counter that carried, or that wrapped to zero instead of the start, would change the upper address or repeat the wrong offset. It also drives a load and an advance on the same edge, where a design that lets advance win would show start+1. Finally it sends advances before any load, which a design without a burst-active condition would let move the offset away from zero.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  // Width of the beat offset; four beats per burst.
  localparam int unsigned BEAT_W = 2;
  localparam int unsigned BEATS  = 1 << BEAT_W;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

endpackage

// File: rtl/bsq_rst_sync.sv
module bsq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bsq_load_ctl.sv
module bsq_load_ctl
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned UP_W  = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_a_i,
  input  logic              strb_b_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              load_o,
  output logic              active_o,
  output logic [BEAT_W-1:0] start_o,
  output logic [UP_W-1:0]   upper_o
);

  logic              active_q, active_d;
  logic [BEAT_W-1:0] start_q,  start_d;
  logic [UP_W-1:0]   upper_q,  upper_d;
  logic              load;

  // Either strobe loads a new burst.
  assign load = strb_a_i | strb_b_i;

  always_comb begin
    active_d = active_q;
    start_d  = start_q;
    upper_d  = upper_q;
    if (load) begin
      active_d = 1'b1;
      start_d  = addr_i[BEAT_W-1:0];
      upper_d  = addr_i[ADDR_W-1:BEAT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      start_q  <= '0;
      upper_q  <= '0;
    end else begin
      active_q <= active_d;
      if (load) begin
        start_q <= start_d;
        upper_q <= upper_d;
      end
    end
  end

  assign load_o   = load;
  assign active_o = active_q;
  assign start_o  = start_q;
  assign upper_o  = upper_q;

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(upper_q)); // R9

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (start_q == $past(addr_i[BEAT_W-1:0])) && active_q); // R2

endmodule

// File: rtl/bsq_beat_cnt.sv
module bsq_beat_cnt
  import bsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              active_i,
  input  logic              adv_n_i,
  output logic [BEAT_W-1:0] beat_o
);

  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              step;

  // Advance counts only inside a burst; a load always wins.
  assign step = active_i & ~adv_n_i & ~load_i;

  always_comb begin
    beat_d = beat_q;
    if (load_i) begin
      beat_d = '0;
    end else if (step) begin
      beat_d = beat_q + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (load_i || step) begin
      beat_q <= beat_d;
    end
  end

  assign beat_o = beat_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> beat_q == '0); // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !adv_n_i && !load_i) |=> beat_q == $past(beat_q) + BEAT_W'(1)); // R3

  AST_NO_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !load_i) |=> beat_q == '0); // R8

endmodule

// File: rtl/bsq_ofs_map.sv
module bsq_ofs_map
  import bsq_pkg::*;
(
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              order_sel_i,
  output logic [BEAT_W-1:0] ofs_o
);

  logic [BEAT_W-1:0] lin_ofs;
  logic [BEAT_W-1:0] ilv_ofs;
  order_e            order;

  assign order = order_e'(order_sel_i);

  // Linear order: add modulo the burst length, carry dropped.
  assign lin_ofs = start_i + beat_i;

  // Interleaved order: one XOR per offset bit.
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_ofs[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order)
      ORD_LINEAR:     ofs_o = lin_ofs;
      ORD_INTERLEAVE: ofs_o = ilv_ofs;
      default:        ofs_o = lin_ofs;
    endcase
  end

  AST_BEAT0_IS_START: assert final (beat_i != '0 || ofs_o == start_i); // R4

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SYNC_STGS = 2,
  localparam int unsigned UP_W     = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_a_i,
  input  logic              strb_b_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_n_i,
  input  logic              order_sel_i,
  output logic [1:0]        beat_ofs_o,
  output logic [ADDR_W-1:0] burst_addr_o
);

  logic              rst_sync_n;
  logic              load;
  logic              active;
  logic [BEAT_W-1:0] start;
  logic [UP_W-1:0]   upper;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] ofs;

  bsq_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  bsq_load_ctl #(.ADDR_W(ADDR_W)) u_load (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .strb_a_i (strb_a_i),
    .strb_b_i (strb_b_i),
    .addr_i   (start_addr_i),
    .load_o   (load),
    .active_o (active),
    .start_o  (start),
    .upper_o  (upper)
  );

  bsq_beat_cnt u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (load),
    .active_i (active),
    .adv_n_i  (adv_n_i),
    .beat_o   (beat)
  );

  bsq_ofs_map u_map (
    .start_i     (start),
    .beat_i      (beat),
    .order_sel_i (order_sel_i),
    .ofs_o       (ofs)
  );

  assign beat_ofs_o   = ofs;
  assign burst_addr_o = {upper, ofs};

  AST_LOAD_OFS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strb_a_i || strb_b_i) |=> beat_ofs_o == $past(start_addr_i[1:0])); // R2

  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strb_a_i && !strb_b_i && adv_n_i) |=> $stable(burst_addr_o)); // R3

  AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strb_a_i && !strb_b_i) |=> $stable(burst_addr_o[ADDR_W-1:2])); // R6

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_sync_n |-> burst_addr_o == '0); // R1

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int AW = 16;

  typedef struct {
    logic [1:0]    ofs;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strb_a = 1'b0, strb_b = 1'b0, adv_n = 1'b1, order_sel = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0]    ofs;
  logic [AW-1:0] addr;

  int total = 0;
  int bad   = 0;
  exp_t q[$];

  logic          m_act;
  logic [1:0]    m_start, m_beat;
  logic [AW-3:0] m_up;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb_a_i     (strb_a),
    .strb_b_i     (strb_b),
    .start_addr_i (start_addr),
    .adv_n_i      (adv_n),
    .order_sel_i  (order_sel),
    .beat_ofs_o   (ofs),
    .burst_addr_o (addr)
  );

  task automatic check(input string tag, input logic [1:0] e_ofs, input logic [AW-1:0] e_addr);
    total++;
    if (ofs !== e_ofs || addr !== e_addr) begin
      bad++;
      $display("FAIL %s: ofs=%0d addr=%h expected ofs=%0d addr=%h", tag, ofs, addr, e_ofs, e_addr);
    end
  endtask

  // Monitor: compare each result shortly after the edge that produced it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, e.ofs, e.addr);
      end
    end
  end

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic step(input logic sa, input logic sb, input logic [AW-1:0] a,
                      input logic an, input string tag);
    exp_t e;
    @(negedge clk);
    strb_a = sa; strb_b = sb; start_addr = a; adv_n = an;
    if (sa || sb) begin
      m_act = 1'b1; m_start = a[1:0]; m_up = a[AW-1:2]; m_beat = 2'd0;
    end else if (m_act && !an) begin
      m_beat = m_beat + 2'd1;
    end
    e.ofs  = order_sel ? (m_start ^ m_beat) : (m_start + m_beat);
    e.addr = {m_up, e.ofs};
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; strb_a = 0; strb_b = 0; adv_n = 1'b1; start_addr = '0;
    order_sel = mode;
    m_act = 0; m_start = 0; m_beat = 0; m_up = 0;
    @(negedge clk);
    check("R1 in reset", 2'd0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 2'd0, '0);
  endtask

  task automatic drain;
    @(posedge clk);
    #3;
  endtask

  initial begin
    do_reset(1'b0);
    // R8: advances before any load do nothing
    step(0, 0, 16'hFFFF, 0, "R8 idle adv");
    step(0, 0, 16'hFFFF, 0, "R8 idle adv");
    // R4 / R6: linear from 2 with upper bits all ones, five advances
    step(1, 0, 16'hFFFE, 1, "R2 load strobe A");
    for (int i = 0; i < 5; i++) step(0, 0, 16'h0000, 0, "R4 R6 linear step");
    // R3: hold with advance high
    step(0, 0, 16'h1234, 1, "R3 hold");
    step(0, 0, 16'h1234, 1, "R3 hold");
    // R2: strobe B, linear from 1
    step(0, 1, 16'hA5A1, 1, "R2 load strobe B");
    for (int i = 0; i < 4; i++) step(0, 0, 16'h0000, 0, "R4 linear from 1");
    // R7: load with advance low in same cycle
    step(1, 1, 16'h0F03, 0, "R7 load wins");
    step(0, 0, 16'h0000, 0, "R4 R9 after load");
    drain();

    do_reset(1'b1);
    step(0, 0, 16'h0000, 0, "R8 idle adv interleaved");
    step(1, 0, 16'hC001, 1, "R2 load interleaved");
    for (int i = 0; i < 5; i++) step(0, 0, 16'h0000, 0, "R5 R6 interleaved from 1");
    step(0, 1, 16'hFFFE, 1, "R2 load interleaved 2");
    for (int i = 0; i < 2; i++) step(0, 0, 16'h0000, 0, "R5 interleaved from 2");
    step(0, 0, 16'h0000, 1, "R3 hold interleaved");
    step(0, 1, 16'h8003, 0, "R7 load wins interleaved");
    for (int i = 0; i < 4; i++) step(0, 0, 16'h0000, 0, "R5 R9 interleaved from 3");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500us;
    bad++;
    total++;
    $display("FAIL watchdog: expected finish, got timeout");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule